// File: doc/BRIEF.md
# Device Error Signaling Front End

This block sits at the error-detection edge of a PCI Express function. Each cycle it can take one error event. An event carries a status vector that should have exactly one bit set, a flag that says whether it is correctable, a flag that allows an uncorrectable nonfatal error to be downgraded to an advisory report, an unsupported-request flag and the 16-bit requester ID of the source. The block records the event in the device status bits and in the correctable and uncorrectable error status registers. It then applies the masks, the severity register, the reporting enables and the system-error enable to decide whether an error message goes out, and at which severity.

Uncorrectable events that are not masked raise a one-cycle request toward a separate header-log block. That block reports through `log_full` that it cannot store another record. When a request meets a full log, the block schedules its own correctable header-log-overflow event. That event runs once the message of the original event has been accepted. Configuration enables and masks arrive as plain input ports. The severity register is held inside the block and has a write port. Each status register has a write-one-to-clear port.

Outgoing messages use a valid/ready handshake. While a message or a scheduled overflow event is pending, `ev_ready` stays low and no new event is taken.

Top module: `dev_err_report`

## Requirements
- R1: An event is taken when `ev_valid` and `ev_ready` are both high at a clock edge. Its status vector is ANDed with the supported set for its class: correctable 0x0000F1C1, uncorrectable 0x03FFF030. If the result does not have exactly one bit set, the event is consumed and changes no status, emits no message and makes no log request.
- R2: The severity register resets to 0x00462030, which makes uncorrectable bits 4, 5, 13, 17, 18 and 22 fatal and all other uncorrectable bits nonfatal. A write through `sev_we` stores `sev_wdata` ANDed with the uncorrectable supported set. An event taken in the same cycle as a write uses the old value.
- R3: A correctable event sets `dev_sts[0]` and its bit in `cor_sts`. If that bit is set in `cor_mask`, or `cor_rep_en` is low, no message is sent. Otherwise a message with `msg_sev` 0 is sent.
- R4: An uncorrectable event whose bit is set in `unc_mask` sets its `unc_sts` bit and the fatal or nonfatal bit of `dev_sts`, but makes no log request and sends no message.
- R5: An unmasked uncorrectable event sets its `unc_sts` bit and sets `dev_sts[2]` if it is fatal or `dev_sts[1]` if it is nonfatal. In the cycle after it is taken, `log_req` is high for one cycle, with `log_bit` equal to the event bit and `log_src` equal to the event source.
- R6: A nonfatal uncorrectable event with `ev_adv` high is reported as correctable: it sets `dev_sts[0]`, `cor_sts[13]` and its own `unc_sts` bit. It makes a log request only if its bit is clear in `unc_mask`. Its message is sent with `msg_sev` 0 under the rules of R3, applied to bit 13. A fatal event ignores `ev_adv`.
- R7: An event with `ev_ur` high sets `dev_sts[3]`. A correctable or advisory message is then suppressed when `ur_rep_en` is low. An uncorrectable message is suppressed when both `ur_rep_en` and `serr_en` are low.
- R8: An unmasked fatal event sends a message with `msg_sev` 2 when `serr_en` or `fat_rep_en` is high. An unmasked nonfatal event sends a message with `msg_sev` 1 when `serr_en` or `nf_rep_en` is high. `msg_sev` is never 3.
- R9: If a log request is made while `log_full` is high, then after the original message has been accepted the block processes a correctable event on bit 15 with the same source. That event follows R3 and uses no unsupported-request flag.
- R10: `msg_valid` stays high, with `msg_sev` and `msg_src` stable, until `msg_ready` is seen high at a clock edge. `ev_ready` is low whenever a message or a scheduled overflow event is pending.
- R11: A one in `dev_clr`, `cor_clr` or `unc_clr` clears the matching status bit at the clock edge. A bit set by an event at the same edge stays set.
- R12: After reset, all status registers are zero, `msg_valid` and `log_req` are low and `ev_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Error event present |
| ev_ready | output | 1 | Event is taken at this edge if valid |
| ev_status | input | 32 | One-hot error status bit |
| ev_cor | input | 1 | Event is correctable |
| ev_adv | input | 1 | Nonfatal event may be reported as advisory |
| ev_ur | input | 1 | Event is an unsupported request |
| ev_src | input | 16 | Requester ID of the error source |
| cor_mask | input | 32 | Correctable mask |
| unc_mask | input | 32 | Uncorrectable mask |
| sev_we | input | 1 | Severity register write strobe |
| sev_wdata | input | 32 | Severity register write data |
| serr_en | input | 1 | System-error enable |
| cor_rep_en | input | 1 | Correctable reporting enable |
| nf_rep_en | input | 1 | Nonfatal reporting enable |
| fat_rep_en | input | 1 | Fatal reporting enable |
| ur_rep_en | input | 1 | Unsupported-request reporting enable |
| dev_clr | input | 4 | Write-one-to-clear for device status |
| cor_clr | input | 32 | Write-one-to-clear for correctable status |
| unc_clr | input | 32 | Write-one-to-clear for uncorrectable status |
| dev_sts | output | 4 | Device status: 0 correctable, 1 nonfatal, 2 fatal, 3 unsupported request |
| cor_sts | output | 32 | Correctable error status |
| unc_sts | output | 32 | Uncorrectable error status |
| msg_valid | output | 1 | Error message pending |
| msg_ready | input | 1 | Error message accepted |
| msg_sev | output | 2 | Message severity: 0 correctable, 1 nonfatal, 2 fatal |
| msg_src | output | 16 | Source ID carried by the message |
| log_req | output | 1 | Header-log request pulse |
| log_bit | output | 32 | Status bit of the logged error |
| log_src | output | 16 | Source ID of the logged error |
| log_full | input | 1 | Header log cannot accept another record |

## Verification
Directed patterns hit one decision at a time. A fatal and a nonfatal uncorrectable bit under the reset severity show that classification comes from the severity register. A masked bit sets status but produces no log request or message, which separates masking from the reporting enables. The advisory flag is applied to both a nonfatal and a fatal bit to show that only the nonfatal one is downgraded. Unsupported-request events are sent with `serr_en` both set and clear to show how the two suppression paths differ. A log-full event, with `msg_ready` held low for several cycles, shows that the overflow event follows the accepted message and not the original event. A long stretch of random events, masks, enables and back-pressure is then compared cycle by cycle against a behavioural model.

// File: rtl/dev_err_report.sv
module dev_err_report #(
  parameter int SRC_W = 16,
  parameter int ST_W = 32,
  parameter logic [ST_W-1:0] COR_SUP = 32'h0000_F1C1,
  parameter logic [ST_W-1:0] UNC_SUP = 32'h03FF_F030,
  parameter logic [ST_W-1:0] SEV_RST = 32'h0046_2030,
  parameter int ADV_POS = 13,
  parameter int HLO_POS = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [ST_W-1:0]  ev_status,
  input  logic             ev_cor,
  input  logic             ev_adv,
  input  logic             ev_ur,
  input  logic [SRC_W-1:0] ev_src,
  input  logic [ST_W-1:0]  cor_mask,
  input  logic [ST_W-1:0]  unc_mask,
  input  logic             sev_we,
  input  logic [ST_W-1:0]  sev_wdata,
  input  logic             serr_en,
  input  logic             cor_rep_en,
  input  logic             nf_rep_en,
  input  logic             fat_rep_en,
  input  logic             ur_rep_en,
  input  logic [3:0]       dev_clr,
  input  logic [ST_W-1:0]  cor_clr,
  input  logic [ST_W-1:0]  unc_clr,
  output logic [3:0]       dev_sts,
  output logic [ST_W-1:0]  cor_sts,
  output logic [ST_W-1:0]  unc_sts,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [1:0]       msg_sev,
  output logic [SRC_W-1:0] msg_src,
  output logic             log_req,
  output logic [ST_W-1:0]  log_bit,
  output logic [SRC_W-1:0] log_src,
  input  logic             log_full
);

  localparam logic [ST_W-1:0] ONE_BIT = {{(ST_W-1){1'b0}}, 1'b1};
  localparam logic [ST_W-1:0] ADV_BIT = ONE_BIT << ADV_POS;
  localparam logic [ST_W-1:0] HLO_BIT = ONE_BIT << HLO_POS;
  localparam logic [1:0] SEV_COR = 2'd0;
  localparam logic [1:0] SEV_NF  = 2'd1;
  localparam logic [1:0] SEV_FAT = 2'd2;

  logic [ST_W-1:0]  sev_q, cur_st, bits, cbit, cset, uset;
  logic [SRC_W-1:0] cur_src, ovf_src;
  logic             ovf_pend, inj, go, one, do_ev;
  logic             cur_cor, cur_adv, cur_ur;
  logic             fatal, adv, cor_path, unc_reg, unc_hit, cor_hit, log_need, send;
  logic [1:0]       sev_code;
  logic [3:0]       dset;

  assign ev_ready = ~msg_valid & ~ovf_pend;
  assign inj      = ovf_pend & ~msg_valid;
  assign go       = (ev_valid & ev_ready) | inj;

  assign cur_st  = inj ? HLO_BIT : ev_status;
  assign cur_cor = inj | ev_cor;
  assign cur_adv = ~inj & ev_adv;
  assign cur_ur  = ~inj & ev_ur;
  assign cur_src = inj ? ovf_src : ev_src;

  assign bits  = cur_st & (cur_cor ? COR_SUP : UNC_SUP);
  assign one   = ($countones(bits) == 1);
  assign do_ev = go & one;

  assign fatal    = ~cur_cor & (|(bits & sev_q));
  assign adv      = ~cur_cor & ~fatal & cur_adv;
  assign cor_path = cur_cor | adv;
  assign unc_reg  = ~cur_cor & ~adv;
  assign cbit     = cur_cor ? bits : ADV_BIT;
  assign unc_hit  = |(bits & unc_mask);
  assign cor_hit  = |(cbit & cor_mask);
  assign log_need = ~cur_cor & ~unc_hit;

  always_comb begin
    send     = 1'b0;
    sev_code = SEV_COR;
    if (cor_path) begin
      send = ~cor_hit & cor_rep_en & ~(cur_ur & ~ur_rep_en);
    end else begin
      sev_code = fatal ? SEV_FAT : SEV_NF;
      send = ~unc_hit & ~(cur_ur & ~ur_rep_en & ~serr_en) &
             (serr_en | (fatal ? fat_rep_en : nf_rep_en));
    end
  end

  assign dset = {cur_ur, unc_reg & fatal, unc_reg & ~fatal, cor_path};
  assign cset = cor_path ? cbit : '0;
  assign uset = cur_cor ? '0 : bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_sts <= '0;
      cor_sts <= '0;
      unc_sts <= '0;
      sev_q   <= SEV_RST;
    end else begin
      dev_sts <= (dev_sts & ~dev_clr) | (do_ev ? dset : 4'b0);
      cor_sts <= (cor_sts & ~cor_clr) | (do_ev ? cset : '0);
      unc_sts <= (unc_sts & ~unc_clr) | (do_ev ? uset : '0);
      if (sev_we) sev_q <= sev_wdata & UNC_SUP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_sev   <= SEV_COR;
      msg_src   <= '0;
    end else if (do_ev & send) begin
      msg_valid <= 1'b1;
      msg_sev   <= sev_code;
      msg_src   <= cur_src;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_req  <= 1'b0;
      log_bit  <= '0;
      log_src  <= '0;
      ovf_pend <= 1'b0;
      ovf_src  <= '0;
    end else begin
      log_req <= do_ev & log_need;
      if (do_ev & log_need) begin
        log_bit <= bits;
        log_src <= cur_src;
      end
      if (inj) begin
        ovf_pend <= 1'b0;
      end else if (do_ev & log_need & log_full) begin
        ovf_pend <= 1'b1;
        ovf_src  <= cur_src;
      end
    end
  end

endmodule

// File: rtl/dev_err_report_chk.sv
module dev_err_report_chk #(
  parameter int SRC_W = 16,
  parameter int ST_W = 32,
  parameter logic [ST_W-1:0] COR_SUP = 32'h0000_F1C1,
  parameter logic [ST_W-1:0] UNC_SUP = 32'h03FF_F030
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [ST_W-1:0]  ev_status,
  input logic             ev_cor,
  input logic             ev_ur,
  input logic [ST_W-1:0]  unc_mask,
  input logic [3:0]       dev_sts,
  input logic [ST_W-1:0]  cor_sts,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [1:0]       msg_sev,
  input logic [SRC_W-1:0] msg_src,
  input logic             log_req,
  input logic [ST_W-1:0]  log_bit
);

  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready &&
    ($countones(ev_status & (ev_cor ? COR_SUP : UNC_SUP)) != 1)
    |=> !msg_valid && !log_req);

  assert_cor_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_cor && ($countones(ev_status & COR_SUP) == 1)
    |=> (cor_sts & $past(ev_status & COR_SUP)) == $past(ev_status & COR_SUP));

  assert_masked_nolog_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !ev_cor && ($countones(ev_status & UNC_SUP) == 1) &&
    ((ev_status & UNC_SUP & unc_mask) != '0)
    |=> !log_req);

  assert_log_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> ($countones(log_bit) == 1));

  assert_ur_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_ur &&
    ($countones(ev_status & (ev_cor ? COR_SUP : UNC_SUP)) == 1)
    |=> dev_sts[3]);

  assert_sev_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_sev != 2'd3));

  assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_sev) && $stable(msg_src));

  assert_busy_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !ev_ready);

endmodule

bind dev_err_report dev_err_report_chk #(
  .SRC_W(SRC_W), .ST_W(ST_W), .COR_SUP(COR_SUP), .UNC_SUP(UNC_SUP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_status(ev_status), .ev_cor(ev_cor), .ev_ur(ev_ur), .unc_mask(unc_mask),
  .dev_sts(dev_sts), .cor_sts(cor_sts), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_sev(msg_sev), .msg_src(msg_src),
  .log_req(log_req), .log_bit(log_bit)
);

// File: tb/sim_dev_err_report.sv
`timescale 1ns/1ps
module sim_dev_err_report;
  localparam logic [31:0] COR_SUP = 32'h0000_F1C1;
  localparam logic [31:0] UNC_SUP = 32'h03FF_F030;
  localparam logic [31:0] SEV_RST = 32'h0046_2030;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0, ev_cor = 0, ev_adv = 0, ev_ur = 0;
  logic [31:0] ev_status = 0;
  logic [15:0] ev_src = 0;
  logic [31:0] cor_mask = 0, unc_mask = 0, sev_wdata = 0, cor_clr = 0, unc_clr = 0;
  logic sev_we = 0, serr_en = 0, cor_rep_en = 1, nf_rep_en = 1, fat_rep_en = 1, ur_rep_en = 1;
  logic [3:0] dev_clr = 0;
  logic msg_ready = 0, log_full = 0;
  logic ev_ready, msg_valid, log_req;
  logic [3:0] dev_sts;
  logic [31:0] cor_sts, unc_sts, log_bit;
  logic [1:0] msg_sev;
  logic [15:0] msg_src, log_src;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dev_err_report u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_status(ev_status), .ev_cor(ev_cor), .ev_adv(ev_adv), .ev_ur(ev_ur),
    .ev_src(ev_src), .cor_mask(cor_mask), .unc_mask(unc_mask), .sev_we(sev_we),
    .sev_wdata(sev_wdata), .serr_en(serr_en), .cor_rep_en(cor_rep_en),
    .nf_rep_en(nf_rep_en), .fat_rep_en(fat_rep_en), .ur_rep_en(ur_rep_en),
    .dev_clr(dev_clr), .cor_clr(cor_clr), .unc_clr(unc_clr), .dev_sts(dev_sts),
    .cor_sts(cor_sts), .unc_sts(unc_sts), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_sev(msg_sev), .msg_src(msg_src),
    .log_req(log_req), .log_bit(log_bit), .log_src(log_src), .log_full(log_full)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [3:0]  m_dev;
  logic [31:0] m_cor, m_unc, m_sev, m_lb;
  logic [1:0]  m_ms;
  logic [15:0] m_msrc, m_ls, m_osrc;
  bit m_mv, m_lr, m_ovf;

  task automatic run_event(input logic [31:0] st, input bit cor, input bit adv,
                           input bit ur, input logic [15:0] src);
    logic [31:0] b, cb;
    bit fatal, send, logit;
    logic [1:0] sv;
    b = st & (cor ? COR_SUP : UNC_SUP);
    if ($countones(b) != 1) return;
    send = 0; logit = 0; sv = 0;
    fatal = !cor && ((b & m_sev) != 0);
    if (ur) m_dev[3] = 1'b1;
    if (cor || (!fatal && adv)) begin
      cb = cor ? b : (32'h1 << 13);
      m_dev[0] = 1'b1;
      m_cor |= cb;
      if (!cor) begin
        m_unc |= b;
        logit = ((b & unc_mask) == 0);
      end
      send = ((cb & cor_mask) == 0) && cor_rep_en && !(ur && !ur_rep_en);
    end else begin
      if (fatal) m_dev[2] = 1'b1; else m_dev[1] = 1'b1;
      m_unc |= b;
      if ((b & unc_mask) == 0) begin
        logit = 1;
        sv = fatal ? 2'd2 : 2'd1;
        if (ur && !ur_rep_en && !serr_en) send = 0;
        else send = serr_en || (fatal ? fat_rep_en : nf_rep_en);
      end
    end
    if (send) begin m_mv = 1; m_ms = sv; m_msrc = src; end
    if (logit) begin
      m_lr = 1; m_lb = b; m_ls = src;
      if (log_full) begin m_ovf = 1; m_osrc = src; end
    end
  endtask

  always @(posedge clk) begin : model
    bit rdy, inj;
    if (!rst_n) begin
      m_dev = 0; m_cor = 0; m_unc = 0; m_sev = SEV_RST;
      m_mv = 0; m_ms = 0; m_msrc = 0; m_lr = 0; m_lb = 0; m_ls = 0;
      m_ovf = 0; m_osrc = 0;
    end else begin
      rdy = !m_mv && !m_ovf;
      inj = m_ovf && !m_mv;
      m_lr = 0;
      if (m_mv && msg_ready) m_mv = 0;
      m_dev &= ~dev_clr; m_cor &= ~cor_clr; m_unc &= ~unc_clr;
      if (ev_valid && rdy) run_event(ev_status, ev_cor, ev_adv, ev_ur, ev_src);
      else if (inj) begin
        m_ovf = 0;
        run_event(32'h1 << 15, 1, 0, 0, m_osrc);
      end
      if (sev_we) m_sev = sev_wdata & UNC_SUP;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 model", "dev_sts", {28'd0, dev_sts}, {28'd0, m_dev});
      chk("R3 model", "cor_sts", cor_sts, m_cor);
      chk("R4 model", "unc_sts", unc_sts, m_unc);
      chk("R10 model", "ev_ready", {31'd0, ev_ready}, {31'd0, !m_mv && !m_ovf});
      chk("R8 model", "msg_valid", {31'd0, msg_valid}, {31'd0, m_mv});
      if (m_mv) begin
        chk("R8 model", "msg_sev", {30'd0, msg_sev}, {30'd0, m_ms});
        chk("R8 model", "msg_src", {16'd0, msg_src}, {16'd0, m_msrc});
      end
      chk("R5 model", "log_req", {31'd0, log_req}, {31'd0, m_lr});
      if (m_lr) begin
        chk("R5 model", "log_bit", log_bit, m_lb);
        chk("R5 model", "log_src", {16'd0, log_src}, {16'd0, m_ls});
      end
    end
  end

  task automatic send(input logic [31:0] st, input bit c, input bit a,
                      input bit u, input logic [15:0] s);
    ev_status = st; ev_cor = c; ev_adv = a; ev_ur = u; ev_src = s; ev_valid = 1;
    while (!ev_ready) begin msg_ready = 1; @(negedge clk); end
    msg_ready = 0;
    @(negedge clk);
    ev_valid = 0; ev_adv = 0; ev_ur = 0;
  endtask

  task automatic take_msg();
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic clr_all();
    dev_clr = 4'hF; cor_clr = '1; unc_clr = '1;
    @(negedge clk);
    dev_clr = 0; cor_clr = 0; unc_clr = 0;
  endtask

  task automatic chk_msg(input string req, input bit v, input logic [1:0] sv,
                         input logic [15:0] s);
    chk(req, "msg_valid", {31'd0, msg_valid}, {31'd0, v});
    if (v) begin
      chk(req, "msg_sev", {30'd0, msg_sev}, {30'd0, sv});
      chk(req, "msg_src", {16'd0, msg_src}, {16'd0, s});
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "dev_sts", {28'd0, dev_sts}, 0);
    chk("R12", "cor_sts", cor_sts, 0);
    chk("R12", "unc_sts", unc_sts, 0);
    chk("R12", "msg_valid", {31'd0, msg_valid}, 0);
    chk("R12", "log_req", {31'd0, log_req}, 0);
    chk("R12", "ev_ready", {31'd0, ev_ready}, 1);

    // R2 default severity, R5 logging
    send(32'h1 << 18, 0, 0, 0, 16'h1111);
    chk_msg("R2", 1, 2'd2, 16'h1111);
    chk("R5", "dev_sts", {28'd0, dev_sts}, 32'h4);
    chk("R5", "unc_sts", unc_sts, 32'h1 << 18);
    chk("R5", "log_req", {31'd0, log_req}, 1);
    chk("R5", "log_bit", log_bit, 32'h1 << 18);
    chk("R5", "log_src", {16'd0, log_src}, 32'h1111);
    take_msg();
    chk("R10", "msg_valid after accept", {31'd0, msg_valid}, 0);
    send(32'h1 << 14, 0, 0, 0, 16'h1112);
    chk_msg("R2", 1, 2'd1, 16'h1112);
    chk("R5", "dev_sts", {28'd0, dev_sts}, 32'h6);
    take_msg();

    // R1 rejection
    send(32'h3 << 12, 0, 0, 0, 16'h5);
    chk_msg("R1", 0, 0, 0);
    chk("R1", "log_req", {31'd0, log_req}, 0);
    chk("R1", "unc_sts", unc_sts, (32'h1 << 18) | (32'h1 << 14));
    send(32'h1, 0, 0, 0, 16'h5);
    chk_msg("R1", 0, 0, 0);
    chk("R1", "unc_sts", unc_sts, (32'h1 << 18) | (32'h1 << 14));
    send(32'h0, 1, 0, 0, 16'h5);
    chk("R1", "cor_sts", cor_sts, 0);

    // R11 clears
    clr_all();
    chk("R11", "dev_sts", {28'd0, dev_sts}, 0);
    chk("R11", "unc_sts", unc_sts, 0);

    // R3 correctable
    send(32'h1 << 6, 1, 0, 0, 16'h2222);
    chk_msg("R3", 1, 2'd0, 16'h2222);
    chk("R3", "dev_sts", {28'd0, dev_sts}, 32'h1);
    chk("R3", "cor_sts", cor_sts, 32'h1 << 6);
    chk("R3", "log_req", {31'd0, log_req}, 0);
    take_msg();
    cor_mask = 32'h1 << 6;
    send(32'h1 << 6, 1, 0, 0, 16'h2223);
    chk_msg("R3 masked", 0, 0, 0);
    cor_mask = 0; cor_rep_en = 0;
    send(32'h1 << 7, 1, 0, 0, 16'h2224);
    chk_msg("R3 disabled", 0, 0, 0);
    chk("R3", "cor_sts", cor_sts, 32'hC0);
    cor_rep_en = 1;

    // R4 masked uncorrectable
    clr_all();
    unc_mask = 32'h1 << 12;
    send(32'h1 << 12, 0, 0, 0, 16'h3000);
    chk_msg("R4", 0, 0, 0);
    chk("R4", "unc_sts", unc_sts, 32'h1 << 12);
    chk("R4", "dev_sts", {28'd0, dev_sts}, 32'h2);
    chk("R4", "log_req", {31'd0, log_req}, 0);
    unc_mask = 0;

    // R6 advisory
    clr_all();
    send(32'h1 << 15, 0, 1, 0, 16'h4000);
    chk_msg("R6", 1, 2'd0, 16'h4000);
    chk("R6", "cor_sts", cor_sts, 32'h1 << 13);
    chk("R6", "unc_sts", unc_sts, 32'h1 << 15);
    chk("R6", "dev_sts", {28'd0, dev_sts}, 32'h1);
    chk("R6", "log_bit", log_bit, 32'h1 << 15);
    take_msg();
    send(32'h1 << 4, 0, 1, 0, 16'h4001);
    chk_msg("R6 fatal ignores adv", 1, 2'd2, 16'h4001);
    chk("R6", "dev_sts", {28'd0, dev_sts}, 32'h5);
    take_msg();
    clr_all();
    unc_mask = 32'h1 << 16;
    send(32'h1 << 16, 0, 1, 0, 16'h4002);
    chk("R6 masked", "log_req", {31'd0, log_req}, 0);
    chk("R6 masked", "unc_sts", unc_sts, 32'h1 << 16);
    chk_msg("R6 masked", 1, 2'd0, 16'h4002);
    take_msg();
    unc_mask = 0;

    // R7 unsupported request
    clr_all();
    ur_rep_en = 0; serr_en = 0;
    send(32'h1 << 20, 0, 0, 1, 16'h5000);
    chk_msg("R7", 0, 0, 0);
    chk("R7", "dev_sts", {28'd0, dev_sts}, 32'hA);
    chk("R7", "log_req", {31'd0, log_req}, 1);
    serr_en = 1;
    send(32'h1 << 20, 0, 0, 1, 16'h5001);
    chk_msg("R7 serr", 1, 2'd1, 16'h5001);
    take_msg();
    send(32'h1, 1, 0, 1, 16'h5002);
    chk_msg("R7 cor", 0, 0, 0);
    chk("R7", "dev_sts", {28'd0, dev_sts}, 32'hB);
    serr_en = 0; ur_rep_en = 1;

    // R8 reporting enables
    clr_all();
    fat_rep_en = 0;
    send(32'h1 << 5, 0, 0, 0, 16'h6000);
    chk_msg("R8", 0, 0, 0);
    chk("R8", "log_req", {31'd0, log_req}, 1);
    serr_en = 1;
    send(32'h1 << 5, 0, 0, 0, 16'h6001);
    chk_msg("R8 serr", 1, 2'd2, 16'h6001);
    take_msg();
    serr_en = 0; nf_rep_en = 0;
    send(32'h1 << 14, 0, 0, 0, 16'h6002);
    chk_msg("R8 nf off", 0, 0, 0);
    nf_rep_en = 1; fat_rep_en = 1;

    // R2 severity write
    sev_we = 1; sev_wdata = '1;
    @(negedge clk);
    sev_we = 0;
    send(32'h1 << 14, 0, 0, 0, 16'h7000);
    chk_msg("R2 write", 1, 2'd2, 16'h7000);
    take_msg();
    sev_we = 1; sev_wdata = 0;
    @(negedge clk);
    sev_we = 0;
    send(32'h1 << 18, 0, 0, 0, 16'h7001);
    chk_msg("R2 write", 1, 2'd1, 16'h7001);
    take_msg();
    sev_we = 1; sev_wdata = SEV_RST;
    @(negedge clk);
    sev_we = 0;

    // R11 set wins over clear
    unc_clr = '1;
    send(32'h1 << 19, 0, 0, 0, 16'h7100);
    unc_clr = 0;
    chk("R11", "unc_sts set wins", unc_sts, 32'h1 << 19);
    take_msg();

    // R9 overflow, R10 hold
    clr_all();
    log_full = 1;
    send(32'h1 << 16, 0, 0, 0, 16'h3333);
    log_full = 0;
    chk_msg("R9", 1, 2'd1, 16'h3333);
    chk("R10", "ev_ready busy", {31'd0, ev_ready}, 0);
    repeat (3) @(negedge clk);
    chk_msg("R10 hold", 1, 2'd1, 16'h3333);
    take_msg();
    chk("R10", "msg_valid", {31'd0, msg_valid}, 0);
    chk("R10", "ev_ready ovf pending", {31'd0, ev_ready}, 0);
    @(negedge clk);
    chk_msg("R9 injected", 1, 2'd0, 16'h3333);
    chk("R9", "cor_sts", cor_sts, 32'h1 << 15);
    chk("R9", "dev_sts", {28'd0, dev_sts}, 32'h3);
    take_msg();
    chk("R9", "ev_ready", {31'd0, ev_ready}, 1);

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom % 8;
      ev_valid = $urandom % 2;
      ev_cor = $urandom % 2;
      ev_adv = $urandom % 2;
      ev_ur = ($urandom % 4) == 0;
      ev_src = 16'($urandom);
      if (k == 0) ev_status = 0;
      else if (k == 1) ev_status = (32'h1 << ($urandom % 32)) | (32'h1 << ($urandom % 32));
      else ev_status = 32'h1 << ($urandom % 32);
      msg_ready = ($urandom % 3) != 0;
      log_full = ($urandom % 4) == 0;
      if ((i % 50) == 0) begin
        cor_mask = $urandom & $urandom;
        unc_mask = $urandom & $urandom;
        serr_en = $urandom % 2; cor_rep_en = $urandom % 2;
        nf_rep_en = $urandom % 2; fat_rep_en = $urandom % 2; ur_rep_en = $urandom % 2;
      end
      sev_we = ($urandom % 40) == 0;
      sev_wdata = $urandom;
      dev_clr = (($urandom % 10) == 0) ? 4'($urandom) : 4'h0;
      cor_clr = (($urandom % 10) == 0) ? $urandom : 32'h0;
      unc_clr = (($urandom % 10) == 0) ? $urandom : 32'h0;
      @(negedge clk);
    end
    ev_valid = 0; sev_we = 0; dev_clr = 0; cor_clr = 0; unc_clr = 0;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule